// File: doc/BRIEF.md
# Event Timer Register Bank and Main Counter

This block is the shared front end of a group of event timer channels. It holds the 64-bit free-running main counter, the block-wide configuration word, the capability words and the interrupt status word. It also decodes a 32-bit register bus into these words and into a fixed-stride window for each timer channel. The channels keep their own comparators and routing. This bank gives them one-hot write strobes, a word index and the write data. For reads it passes back whatever the channel addressed by the current read presents.

The counter advances by one on each cycle that `tick_en` is high while the global enable is set. Clearing the enable freezes the counter at its value, and software can load it as two 32-bit halves at any time. When the enable goes from clear to set, the bank pulses a re-arm request to every channel whose comparator does not report all ones. Reads are combinational: `bus_rdata` follows `bus_addr` in the same cycle. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `evt_regbank`

## Requirements
- R1: After reset the main counter, the configuration word and the status word are all zero. `glb_en`, `legacy_en`, `cnt_wr_flag` and `tmr_rearm` are low.
- R2: While config bit 0 is set, the counter rises by one on each clock edge at which `tick_en` is high. While that bit is clear, the counter holds its value and ignores `tick_en`. Carries pass from the low half into the high half.
- R3: A write to offset 0x0F0 replaces the low 32 bits of the counter and a write to 0x0F4 replaces the high 32 bits, whether the block is enabled or not. A counter write wins over a tick in the same cycle. A counter write made while enabled raises `cnt_wr_flag` for the one cycle after it. A counter write made while disabled does not.
- R4: Offset 0x000 reads a fixed capability word. Bits 7:0 hold revision 1. Bits 12:8 hold the timer count minus one, with the count clamped to 3..32. Bit 13 reports a 64-bit counter, bit 15 reports legacy routing and bits 31:16 hold a vendor code. Offset 0x004 reads the tick period in femtoseconds. Writes to either offset change nothing.
- R5: A write to offset 0x010 changes only configuration bits 1:0. Bit 0 is the global enable and drives `glb_en`; bit 1 is legacy mode and drives `legacy_en`. All other bits read 0. Offset 0x014 reads 0 and ignores writes.
- R6: A configuration write that takes bit 0 from 0 to 1 drives `tmr_rearm` to the inverse of `tmr_cmp_max` for exactly the one cycle after the write. Any other configuration write leaves `tmr_rearm` at zero.
- R7: Timer channel n owns offsets 0x100 + 0x20·n up to 0x11F + 0x20·n. Its word k (byte offset 4·k) is routed as follows: 0 config low, 1 capability high, 2 comparator low, 3 comparator high, 4 route low, 5 route high. A write to word 0, 2, 3, 4 or 5 raises bit n of `tmr_wr_stb` in that same cycle, with `tmr_wr_word` = k and `tmr_wr_data` = the bus data. Writes to word 1, 6 or 7 raise no strobe.
- R8: A window whose index is at or above the implemented timer count reads 0 and a write to it raises no strobe.
- R9: A read of word 0 to 5 of an implemented channel returns `tmr_rdata`, with `tmr_rd_idx` and `tmr_rd_word` naming the channel and word decoded from `bus_addr`. Words 6 and 7 read 0.
- R10: Status bit n is set at the clock edge at which `tmr_irq_set[n]` is high while enabled. A write to offset 0x020 clears each bit written as 1. A set and a clear of the same bit in one cycle leave the bit set. Sets while disabled are ignored.
- R11: Unmapped offsets read 0 and ignore writes. Any address with bits 1:0 not zero also reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_en | input | 1 | Counter advance request |
| glb_en | output | 1 | Global enable (config bit 0) |
| legacy_en | output | 1 | Legacy mode (config bit 1) |
| count | output | 64 | Main counter value |
| cnt_wr_flag | output | 1 | Counter was written while enabled, one cycle after |
| tmr_wr_stb | output | NT | One-hot write strobe per channel |
| tmr_wr_word | output | 3 | Word index within the channel window |
| tmr_wr_data | output | 32 | Write data for the channel |
| tmr_rd_idx | output | 5 | Channel index decoded for reads |
| tmr_rd_word | output | 3 | Word index decoded for reads |
| tmr_rdata | input | 32 | Read data from the addressed channel |
| tmr_cmp_max | input | NT | Channel comparator equals all ones |
| tmr_rearm | output | NT | Re-arm request, one cycle after enable rises |
| tmr_irq_set | input | NT | Per-channel status set request |

## Verification
Read data and the channel write strobes, word index and data are combinational. The bench drives each access just after a falling edge and samples these results 1 ns later, inside the same cycle. Counter, configuration, status, `cnt_wr_flag` and `tmr_rearm` change at the rising edge that accepts the write or tick. The bench reads them back at the next falling edge, and it checks that `tmr_rearm` has returned to zero one cycle after that. Tick counts are set by holding `tick_en` for an exact number of falling-to-falling intervals, so each run of ticks spans a known number of rising edges.

// File: rtl/evt_regbank_pkg.sv
// Package: shared offsets, widths and decode types for the event timer
// register bank. Assumes 32-bit aligned accesses and a 0x20-byte window
// per timer channel starting at offset 0x100.
package evt_regbank_pkg;

    localparam int CNT_W     = 64;
    localparam int DATA_W    = 32;
    localparam int IDX_W     = 5;
    localparam int WORD_W    = 3;
    localparam int MAX_TMR   = 32;
    localparam int MIN_TMR   = 3;

    localparam logic [31:0] OFS_CAP_LO  = 32'h000;
    localparam logic [31:0] OFS_CAP_HI  = 32'h004;
    localparam logic [31:0] OFS_CFG_LO  = 32'h010;
    localparam logic [31:0] OFS_CFG_HI  = 32'h014;
    localparam logic [31:0] OFS_STATUS  = 32'h020;
    localparam logic [31:0] OFS_CNT_LO  = 32'h0F0;
    localparam logic [31:0] OFS_CNT_HI  = 32'h0F4;
    localparam logic [31:0] OFS_WIN_LO  = 32'h100;
    localparam logic [31:0] OFS_WIN_HI  = 32'h3FF;

    localparam logic [31:0] CFG_WMASK   = 32'h0000_0003;

    typedef enum logic [2:0] {
        GSEL_NONE,
        GSEL_CAP_LO,
        GSEL_CAP_HI,
        GSEL_CFG_LO,
        GSEL_CFG_HI,
        GSEL_STATUS,
        GSEL_CNT_LO,
        GSEL_CNT_HI
    } gsel_e;

    typedef struct packed {
        gsel_e              gsel;
        logic               tmr_valid;
        logic [IDX_W-1:0]   idx;
        logic [WORD_W-1:0]  word;
    } dec_t;

    // Clamp a requested timer count into the supported range.
    function automatic int clamp_tmr(input int n);
        if (n < MIN_TMR) return MIN_TMR;
        if (n > MAX_TMR) return MAX_TMR;
        return n;
    endfunction

    // True for channel words that accept writes.
    function automatic logic word_writable(input logic [WORD_W-1:0] w);
        return (w == 3'd0) || (w >= 3'd2 && w <= 3'd5);
    endfunction

    // True for channel words that return channel data on reads.
    function automatic logic word_readable(input logic [WORD_W-1:0] w);
        return (w <= 3'd5);
    endfunction

endpackage

// File: rtl/evt_addr_decode.sv
// Address decoder: splits a byte address into a global register select or
// a timer channel window (index and word). Assumes ADDR_W >= 10; an
// address with nonzero low two bits selects nothing.
module evt_addr_decode
    import evt_regbank_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NT     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    logic [31:0] a32;
    logic [31:0] win_ofs;
    logic        aligned;
    logic        in_win;

    // Widen and classify the address.
    always_comb begin
        a32     = 32'(addr);
        aligned = (addr[1:0] == 2'b00);
        in_win  = aligned && (a32 >= OFS_WIN_LO) && (a32 <= OFS_WIN_HI);
        win_ofs = a32 - OFS_WIN_LO;
    end

    // Produce the decoded select.
    always_comb begin
        dec.idx       = win_ofs[IDX_W+4:5];
        dec.word      = a32[4:2];
        dec.tmr_valid = in_win && (32'(dec.idx) < 32'(NT));
        dec.gsel      = GSEL_NONE;
        if (aligned) begin
            case (a32)
                OFS_CAP_LO: dec.gsel = GSEL_CAP_LO;
                OFS_CAP_HI: dec.gsel = GSEL_CAP_HI;
                OFS_CFG_LO: dec.gsel = GSEL_CFG_LO;
                OFS_CFG_HI: dec.gsel = GSEL_CFG_HI;
                OFS_STATUS: dec.gsel = GSEL_STATUS;
                OFS_CNT_LO: dec.gsel = GSEL_CNT_LO;
                OFS_CNT_HI: dec.gsel = GSEL_CNT_HI;
                default:    dec.gsel = GSEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/evt_main_counter.sv
// Main counter: 64-bit up counter that advances on tick while running and
// loads either 32-bit half from the bus. A load wins over a tick.
module evt_main_counter
    import evt_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [DATA_W-1:0] ld_data,
    output logic [CNT_W-1:0]  value
);

    // Load, advance or hold the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (ld_lo) begin
            value <= {value[CNT_W-1:DATA_W], ld_data};
        end else if (ld_hi) begin
            value <= {ld_data, value[DATA_W-1:0]};
        end else if (run && tick) begin
            value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/evt_status_reg.sv
// Status word: one sticky bit per channel, set by the channel while the
// block runs, cleared by writing ones. A set beats a clear in one cycle.
module evt_status_reg #(
    parameter int NT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [NT-1:0] set_vec,
    input  logic          clr_wr,
    input  logic [NT-1:0] clr_mask,
    output logic [NT-1:0] status
);

    logic [NT-1:0] clr_eff;
    logic [NT-1:0] set_eff;

    // Qualify the set and clear requests.
    always_comb begin
        clr_eff = clr_wr ? clr_mask : '0;
        set_eff = run ? set_vec : '0;
    end

    // Update the sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_eff) | set_eff;
    end

endmodule

// File: rtl/evt_regbank.sv
// Event timer register bank: holds capability, configuration, status and
// the main counter, and fans channel window accesses out to NT timer
// channels. Reads are combinational; writes commit on the clock edge.
// Assumes the channels return read data for tmr_rd_idx/tmr_rd_word.
module evt_regbank
    import evt_regbank_pkg::*;
#(
    parameter int          NUM_TIMERS = 4,
    parameter int          ADDR_W     = 10,
    parameter logic [31:0] TICK_FS    = 32'd10_000_000,
    parameter logic [15:0] VENDOR     = 16'hE7A0,
    localparam int         NT         = clamp_tmr(NUM_TIMERS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_en,
    output logic              glb_en,
    output logic              legacy_en,
    output logic [63:0]       count,
    output logic              cnt_wr_flag,
    output logic [NT-1:0]     tmr_wr_stb,
    output logic [2:0]        tmr_wr_word,
    output logic [31:0]       tmr_wr_data,
    output logic [4:0]        tmr_rd_idx,
    output logic [2:0]        tmr_rd_word,
    input  logic [31:0]       tmr_rdata,
    input  logic [NT-1:0]     tmr_cmp_max,
    output logic [NT-1:0]     tmr_rearm,
    input  logic [NT-1:0]     tmr_irq_set
);

    localparam logic [31:0] CAP_LO = {VENDOR, 1'b1, 1'b0, 1'b1,
                                      5'(NT - 1), 8'h01};

    dec_t          dec;
    logic [31:0]   cfg_q;
    logic [NT-1:0] status_q;
    logic [NT-1:0] rearm_q;
    logic          flag_q;
    logic          cfg_wr;
    logic          sts_wr;
    logic          cnt_lo_wr;
    logic          cnt_hi_wr;
    logic          en_rise;

    evt_addr_decode #(
        .ADDR_W (ADDR_W),
        .NT     (NT)
    ) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    // Qualify bus writes per global register.
    always_comb begin
        cfg_wr    = bus_wr && (dec.gsel == GSEL_CFG_LO);
        sts_wr    = bus_wr && (dec.gsel == GSEL_STATUS);
        cnt_lo_wr = bus_wr && (dec.gsel == GSEL_CNT_LO);
        cnt_hi_wr = bus_wr && (dec.gsel == GSEL_CNT_HI);
        en_rise   = cfg_wr && bus_wdata[0] && !cfg_q[0];
    end

    // Configuration word: only masked bits follow the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= (bus_wdata & CFG_WMASK) | (cfg_q & ~CFG_WMASK);
    end

    // Re-arm pulse and unexpected-counter-write flag, one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rearm_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            rearm_q <= en_rise ? ~tmr_cmp_max : '0;
            flag_q  <= (cnt_lo_wr || cnt_hi_wr) && cfg_q[0];
        end
    end

    evt_main_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cfg_q[0]),
        .tick    (tick_en),
        .ld_lo   (cnt_lo_wr),
        .ld_hi   (cnt_hi_wr),
        .ld_data (bus_wdata),
        .value   (count)
    );

    evt_status_reg #(
        .NT (NT)
    ) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cfg_q[0]),
        .set_vec  (tmr_irq_set),
        .clr_wr   (sts_wr),
        .clr_mask (bus_wdata[NT-1:0]),
        .status   (status_q)
    );

    // One write strobe per channel window.
    for (genvar n = 0; n < NT; n++) begin : g_stb
        assign tmr_wr_stb[n] = bus_wr && dec.tmr_valid &&
                               (dec.idx == 5'(n)) && word_writable(dec.word);
    end

    // Channel-side write and read addressing.
    always_comb begin
        tmr_wr_word = dec.word;
        tmr_wr_data = bus_wdata;
        tmr_rd_idx  = dec.idx;
        tmr_rd_word = dec.word;
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (dec.tmr_valid) begin
            if (word_readable(dec.word)) bus_rdata = tmr_rdata;
        end else begin
            case (dec.gsel)
                GSEL_CAP_LO: bus_rdata = CAP_LO;
                GSEL_CAP_HI: bus_rdata = TICK_FS;
                GSEL_CFG_LO: bus_rdata = cfg_q;
                GSEL_STATUS: bus_rdata = 32'(status_q);
                GSEL_CNT_LO: bus_rdata = count[31:0];
                GSEL_CNT_HI: bus_rdata = count[63:32];
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign glb_en      = cfg_q[0];
    assign legacy_en   = cfg_q[1];
    assign tmr_rearm   = rearm_q;
    assign cnt_wr_flag = flag_q;

endmodule

// File: rtl/evt_regbank_checker.sv
// Checker: temporal properties of the register bank, bound to the top.
module evt_regbank_checker #(
    parameter int NT = 4,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              tick_en,
    input logic              glb_en,
    input logic [63:0]       count,
    input logic              cnt_wr_flag,
    input logic [NT-1:0]     tmr_wr_stb,
    input logic [NT-1:0]     tmr_rearm,
    input logic [NT-1:0]     tmr_irq_set,
    input logic [NT-1:0]     status_q
);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && tick_en && !bus_wr) |=> (count == $past(count) + 64'd1));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !bus_wr) |=> $stable(count));

    assert_flag_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_flag |-> $past(glb_en) && $past(bus_wr));

    assert_rearm_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_rearm != '0) |-> $rose(glb_en));

    assert_stb_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_wr_stb));

    assert_stb_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |-> (tmr_wr_stb == '0));

    assert_stb_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_wr_stb != '0) |-> (32'(bus_addr) >= 32'h100));

    assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && !bus_wr) |=> ((status_q & $past(tmr_irq_set)) == $past(tmr_irq_set)));

endmodule

bind evt_regbank evt_regbank_checker #(
    .NT     (NT),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .tick_en     (tick_en),
    .glb_en      (glb_en),
    .count       (count),
    .cnt_wr_flag (cnt_wr_flag),
    .tmr_wr_stb  (tmr_wr_stb),
    .tmr_rearm   (tmr_rearm),
    .tmr_irq_set (tmr_irq_set),
    .status_q    (status_q)
);

// File: tb/evt_regbank_bench.sv
`timescale 1ns/1ps
module evt_regbank_bench;

    localparam int NTB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        glb_en, legacy_en, cnt_wr_flag;
    logic [63:0] count;
    logic [NTB-1:0] tmr_wr_stb, tmr_rearm;
    logic [NTB-1:0] tmr_cmp_max = '0;
    logic [NTB-1:0] tmr_irq_set = '0;
    logic [2:0]  tmr_wr_word, tmr_rd_word;
    logic [31:0] tmr_wr_data, tmr_rdata;
    logic [4:0]  tmr_rd_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign tmr_rdata = {8'hC0, 3'b000, tmr_rd_idx, 5'b00000, tmr_rd_word, 8'h5A};

    evt_regbank #(.NUM_TIMERS(NTB), .ADDR_W(10)) u_evt_regbank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .glb_en(glb_en), .legacy_en(legacy_en), .count(count),
        .cnt_wr_flag(cnt_wr_flag), .tmr_wr_stb(tmr_wr_stb),
        .tmr_wr_word(tmr_wr_word), .tmr_wr_data(tmr_wr_data),
        .tmr_rd_idx(tmr_rd_idx), .tmr_rd_word(tmr_rd_word),
        .tmr_rdata(tmr_rdata), .tmr_cmp_max(tmr_cmp_max),
        .tmr_rearm(tmr_rearm), .tmr_irq_set(tmr_irq_set)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        d = bus_rdata;
        @(negedge clk);
    endtask

    function automatic logic [31:0] exp_idle_read(input int a);
        int idx, wd;
        if (a == 'h000) return {16'hE7A0, 8'hA0 | 8'(NTB - 1), 8'h01};
        if (a == 'h004) return 32'd10_000_000;
        if (a >= 'h100) begin
            idx = (a - 'h100) / 32;
            wd  = (a / 4) % 8;
            if (idx < NTB && wd <= 5)
                return {8'hC0, 3'b000, 5'(idx), 5'b00000, 3'(wd), 8'h5A};
        end
        return 32'h0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports
        check("R1 glb_en", 64'(glb_en), 0);
        check("R1 legacy_en", 64'(legacy_en), 0);
        check("R1 count", count, 0);
        check("R1 rearm", 64'(tmr_rearm), 0);
        check("R1 flag", 64'(cnt_wr_flag), 0);

        // R4 R7 R8 R9 R11: sweep every aligned offset in idle state
        for (int a = 0; a < 'h400; a += 4) begin
            bus_read(10'(a), rd);
            if (a < 'h100) check("R4/R11 global read", 64'(rd), 64'(exp_idle_read(a)));
            else           check("R9/R8 window read", 64'(rd), 64'(exp_idle_read(a)));
        end

        // R11: misaligned read and write
        bus_read(10'h001, rd);
        check("R11 misaligned read", 64'(rd), 0);
        bus_write(10'h011, 32'h3);
        check("R11 misaligned write", 64'(glb_en), 0);
        bus_write(10'h0F2, 32'hFFFF);
        check("R11 misaligned counter write", count, 0);

        // R7 R8: write sweep across all windows, strobes sampled in-cycle
        for (int a = 'h100; a < 'h400; a += 4) begin
            int idx, wd;
            logic [NTB-1:0] exp_stb;
            idx = (a - 'h100) / 32;
            wd  = (a / 4) % 8;
            exp_stb = (idx < NTB && (wd == 0 || (wd >= 2 && wd <= 5))) ?
                      NTB'(1 << idx) : '0;
            bus_addr = 10'(a); bus_wdata = 32'(a) ^ 32'h5A5A_0000; bus_wr = 1'b1;
            #1;
            check(idx < NTB ? "R7 strobe" : "R8 strobe out of range",
                  64'(tmr_wr_stb), 64'(exp_stb));
            if (exp_stb != '0) begin
                check("R7 word", 64'(tmr_wr_word), 64'(wd));
                check("R7 data", 64'(tmr_wr_data), 64'(32'(a) ^ 32'h5A5A_0000));
            end
            @(negedge clk);
            bus_wr = 1'b0;
        end

        // R4: capability writes ignored
        bus_write(10'h000, 32'h0);
        bus_write(10'h004, 32'h0);
        bus_read(10'h000, rd);
        check("R4 cap lo after write", 64'(rd), 64'(exp_idle_read(0)));
        bus_read(10'h004, rd);
        check("R4 cap hi after write", 64'(rd), 64'(exp_idle_read(4)));

        // R3: counter halves writable while disabled, no flag
        bus_write(10'h0F0, 32'hFFFF_FFFE);
        check("R3 no flag when disabled", 64'(cnt_wr_flag), 0);
        bus_write(10'h0F4, 32'h0000_0001);
        check("R3 count loaded", count, 64'h1_FFFF_FFFE);

        // R2: disabled counter ignores tick
        tick_en = 1'b1;
        repeat (4) @(negedge clk);
        tick_en = 1'b0;
        check("R2 hold while disabled", count, 64'h1_FFFF_FFFE);

        // R6: enable rise re-arms channels whose comparator is not all ones
        tmr_cmp_max = 4'b0101;
        bus_write(10'h010, 32'h1);
        check("R6 rearm pulse", 64'(tmr_rearm), 64'h0A);
        check("R5 enable", 64'(glb_en), 1);
        @(negedge clk);
        check("R6 rearm one cycle", 64'(tmr_rearm), 0);
        bus_write(10'h010, 32'h1);
        check("R6 no rearm when already on", 64'(tmr_rearm), 0);

        // R2: five ticks with carry into the high half
        tick_en = 1'b1;
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        check("R2 count after 5 ticks", count, 64'h2_0000_0003);
        bus_read(10'h0F0, rd);
        check("R2 count lo read", 64'(rd), 64'h3);
        bus_read(10'h0F4, rd);
        check("R2 count hi read", 64'(rd), 64'h2);

        // R3: write while enabled with tick active: write wins, flag raised
        tick_en = 1'b1;
        bus_write(10'h0F4, 32'h7);
        tick_en = 1'b0;
        check("R3 flag when enabled", 64'(cnt_wr_flag), 1);
        check("R3 write beats tick", count, 64'h7_0000_0003);
        @(negedge clk);
        check("R3 flag one cycle", 64'(cnt_wr_flag), 0);

        // R10: status set, clear, set-beats-clear
        tmr_irq_set = 4'b0110;
        @(negedge clk);
        tmr_irq_set = '0;
        bus_read(10'h020, rd);
        check("R10 status set", 64'(rd), 64'h6);
        bus_write(10'h020, 32'h2);
        bus_read(10'h020, rd);
        check("R10 status clear", 64'(rd), 64'h4);
        tmr_irq_set = 4'b0100;
        bus_write(10'h020, 32'h4);
        tmr_irq_set = '0;
        bus_read(10'h020, rd);
        check("R10 set beats clear", 64'(rd), 64'h4);

        // R5: masked config write, high half ignored
        bus_write(10'h010, 32'hFFFF_FFFF);
        bus_read(10'h010, rd);
        check("R5 config mask", 64'(rd), 64'h3);
        check("R5 legacy", 64'(legacy_en), 1);
        check("R6 no rearm when already on", 64'(tmr_rearm), 0);
        bus_write(10'h014, 32'hFFFF_FFFF);
        bus_read(10'h014, rd);
        check("R5 config hi", 64'(rd), 0);

        // R2 R10: disable freezes counter and ignores status sets
        bus_write(10'h010, 32'h0);
        check("R5 disable", 64'(glb_en), 0);
        tmr_irq_set = 4'b0001;
        tick_en = 1'b1;
        repeat (3) @(negedge clk);
        tick_en = 1'b0;
        tmr_irq_set = '0;
        check("R2 frozen after disable", count, 64'h7_0000_0003);
        bus_read(10'h020, rd);
        check("R10 set ignored while disabled", 64'(rd), 64'h4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule